// File: doc/BRIEF.md
# Time-Multiplexed Parallel I/Q Output Stage

This block collects complex baseband samples (a 16-bit in-phase and a 16-bit quadrature part per channel) from up to eight receive channels and presents them one channel at a time on a single 32-bit parallel bus. A forwarded output clock and a one-slot frame marker go out alongside the bus, so a downstream receiver can latch each word on one edge of that clock and find channel 0 by the marker.

Time is divided into transfer intervals. Each interval has a whole number of output-clock periods, called slots. At the end of every interval all channel inputs are copied into a holding register in the same system-clock cycle. The next interval then walks the active channels in ascending order, one slot each, from that copy. The rate is set by an integer clock divider and by the frame length in slots. Together they set how often the inputs are captured, so the output stage can drop samples (for example, capturing every second input sample) without a separate decimator. The divider, frame length, active channel count, marker slot and clock polarity are configuration inputs. They are read at reset release and again at every interval boundary, never in the middle of a frame.

The output bus follows the forwarded clock and has no valid/ready handshake. A forwarded clock cannot be stalled, so the receiver must accept one word in every slot. The channel inputs are sampled levels and have no handshake either. The producer must hold each sample steady across the cycle that ends an interval.

Top module: `tdm_iq_mux`

## Requirements
- R1: Each output word carries the in-phase sample in bits 31:16 (I bit 15 on bit 31) and the quadrature sample in bits 15:0.
- R2: In slot s of an interval, for s below the active channel count, the bus carries channel s, so channels appear in ascending order starting at 0.
- R3: The channel-count input is a 3-bit code c that selects c+1 active channels (1 to 8).
- R4: An interval lasts F slots, where F is the larger of the frame-length input and the active channel count. Captures are therefore 2·D·F system-clock cycles apart. In slots at or above the channel count, the bus holds the last active channel's word.
- R5: One output-clock period, and so one slot, lasts 2·D system-clock cycles, where D is the divider input and a divider of 0 counts as 1. The clock is at each level for D cycles.
- R6: With the polarity input at 0, the output clock falls when a new word is launched and rises mid-slot. With polarity 1 it is inverted. Data and marker never change on the receiver's sampling edge (the rising edge for polarity 0, the falling edge for polarity 1).
- R7: The frame marker is high for exactly the one slot whose index equals the marker-slot input, and low in every other slot. A marker-slot value at or above the channel count selects slot 0.
- R8: Every word in an interval comes from the inputs present in the cycle that ended the previous interval. Input changes during an interval do not show until the following interval.
- R9: During the first interval after reset, no capture exists yet: the bus reads zero and the marker stays low.
- R10: Configuration inputs are read in the first cycle after reset release and at each interval boundary. A change made mid-interval takes effect only from the next interval.
- R11: While reset is asserted (active low), the bus, the marker and the output clock are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 8 | Output clock divider D (0 treated as 1) |
| cfg_frame_len | input | 8 | Frame length in slots before the channel-count floor |
| cfg_last_ch | input | 3 | Active channel count minus one |
| cfg_sync_slot | input | 3 | Slot index that carries the frame marker |
| cfg_clk_inv | input | 1 | Output clock polarity select |
| ch_i | input | 128 | In-phase samples, channel c at bits 16c+15:16c |
| ch_q | input | 128 | Quadrature samples, channel c at bits 16c+15:16c |
| out_clk | output | 1 | Forwarded output clock |
| out_sync | output | 1 | Frame marker, one slot wide |
| out_data | output | 32 | Multiplexed I/Q word |

## Verification
The bench acts as the receiver: it latches the bus on the sampling edge for the chosen polarity, so a design that launched data on the wrong edge would show the word changing at the instant it is sampled. It drives frames whose length exceeds the channel count to confirm that idle slots hold the last channel rather than showing a stale or zero word, and it sets a marker slot beyond the channel count to catch a design that would drop the marker or place it in an idle slot. It changes inputs and configuration in the middle of an interval. A design without a true snapshot would mix old and new words in one frame, and one without shadowed settings would change the frame shape on the spot. Cycle counts between markers and clock levels, including a zero divider, reveal a wrong capture rate or divide ratio.

// File: rtl/tdm_iq_pkg.sv
package tdm_iq_pkg;
  localparam int MAX_CH = 8;
  localparam int CH_W   = $clog2(MAX_CH);
  localparam int DIV_W  = 8;
  localparam int FLEN_W = 8;

  // settings in force for one transfer interval
  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [FLEN_W-1:0] flen;
    logic [CH_W-1:0]   last_ch;
    logic [CH_W-1:0]   sync_slot;
    logic              clk_inv;
  } tdm_cfg_t;
endpackage

// File: rtl/tdm_rate_gen.sv
module tdm_rate_gen
  import tdm_iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             clk_inv,
  output logic             tick,
  output logic             launch,
  output logic             oclk
);
  localparam int PH_W = DIV_W + 1;

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_last;
  logic [PH_W-1:0] div_ext;

  assign div_ext = {1'b0, div};
  assign ph_last = {div, 1'b0} - PH_W'(1);
  assign tick    = run && (ph == ph_last);
  assign launch  = run && (ph == '0);

  // phase 0 is the launch point; the clock toggles again at phase div
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      oclk <= 1'b0;
    end else if (run) begin
      ph   <= tick ? '0 : ph + PH_W'(1);
      oclk <= clk_inv ? (ph < div_ext) : (ph >= div_ext);
    end
  end
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_iq_pkg::*;
#(
  parameter int NUM_CH = MAX_CH
)(
  input  logic              clk,
  input  logic              rst_n,
  input  tdm_cfg_t          cfg_in,
  input  logic              tick,
  output logic              run,
  output tdm_cfg_t          cfg_act,
  output logic [FLEN_W-1:0] slot,
  output logic              cap_evt,
  output logic              captured
);
  logic [CH_W-1:0]   last_ch_s;
  logic [FLEN_W-1:0] nch_ext;
  tdm_cfg_t          cfg_s;
  logic              last_slot;
  logic              load;

  generate
    if (NUM_CH < MAX_CH) begin : g_clamp_ch
      assign last_ch_s = (cfg_in.last_ch > CH_W'(NUM_CH - 1)) ?
                         CH_W'(NUM_CH - 1) : cfg_in.last_ch;
    end else begin : g_full_ch
      assign last_ch_s = cfg_in.last_ch;
    end
  endgenerate

  assign nch_ext = FLEN_W'(last_ch_s) + FLEN_W'(1);

  // sanitise settings before they enter the shadow register
  always_comb begin
    cfg_s.div       = (cfg_in.div == '0) ? DIV_W'(1) : cfg_in.div;
    cfg_s.flen      = (cfg_in.flen < nch_ext) ? nch_ext : cfg_in.flen;
    cfg_s.last_ch   = last_ch_s;
    cfg_s.sync_slot = (cfg_in.sync_slot > last_ch_s) ? '0 : cfg_in.sync_slot;
    cfg_s.clk_inv   = cfg_in.clk_inv;
  end

  assign last_slot = (slot == cfg_act.flen - FLEN_W'(1));
  assign cap_evt   = run && tick && last_slot;
  assign load      = !run || cap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cfg_act  <= '0;
      slot     <= '0;
      captured <= 1'b0;
    end else begin
      run <= 1'b1;
      if (load) begin
        cfg_act <= cfg_s;
        slot    <= '0;
      end else if (tick) begin
        slot <= slot + FLEN_W'(1);
      end
      if (cap_evt) captured <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_word_mux.sv
module tdm_word_mux
  import tdm_iq_pkg::*;
#(
  parameter int NUM_CH = MAX_CH,
  parameter int SAMP_W = 16,
  localparam int WORD_W = 2 * SAMP_W,
  localparam int BUS_W  = NUM_CH * SAMP_W
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BUS_W-1:0]         ch_i,
  input  logic [BUS_W-1:0]         ch_q,
  input  logic                     cap_evt,
  input  logic                     launch,
  input  logic                     captured,
  input  logic [FLEN_W-1:0]        slot,
  input  logic [CH_W-1:0]          last_ch,
  input  logic [CH_W-1:0]          sync_slot,
  output logic [WORD_W-1:0]        out_data,
  output logic                     out_sync,
  output logic [NUM_CH*WORD_W-1:0] snap_flat
);
  logic [WORD_W-1:0] in_word [NUM_CH];
  logic [WORD_W-1:0] snap    [NUM_CH];
  logic [CH_W-1:0]   sel;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign in_word[c] = {ch_i[c*SAMP_W +: SAMP_W], ch_q[c*SAMP_W +: SAMP_W]};
      assign snap_flat[c*WORD_W +: WORD_W] = snap[c];
    end
  endgenerate

  // idle slots past the last channel re-send the last channel's word
  always_comb begin
    if (slot > FLEN_W'(last_ch)) sel = last_ch;
    else                         sel = slot[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) snap[c] <= '0;
    end else if (cap_evt) begin
      for (int c = 0; c < NUM_CH; c++) snap[c] <= in_word[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_sync <= 1'b0;
    end else if (launch && captured) begin
      out_data <= snap[sel];
      out_sync <= (slot == FLEN_W'(sync_slot));
    end
  end
endmodule

// File: rtl/tdm_iq_mux.sv
module tdm_iq_mux
  import tdm_iq_pkg::*;
#(
  parameter int NUM_CH = MAX_CH,
  parameter int SAMP_W = 16,
  localparam int WORD_W = 2 * SAMP_W,
  localparam int BUS_W  = NUM_CH * SAMP_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [FLEN_W-1:0] cfg_frame_len,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic [CH_W-1:0]   cfg_sync_slot,
  input  logic              cfg_clk_inv,
  input  logic [BUS_W-1:0]  ch_i,
  input  logic [BUS_W-1:0]  ch_q,
  output logic              out_clk,
  output logic              out_sync,
  output logic [WORD_W-1:0] out_data
);
  tdm_cfg_t                 cfg_in;
  tdm_cfg_t                 cfg_act;
  logic                     run;
  logic                     tick;
  logic                     launch;
  logic                     cap_evt;
  logic                     captured;
  logic [FLEN_W-1:0]        slot;
  logic [FLEN_W-1:0]        act_flen;
  logic [NUM_CH*WORD_W-1:0] snap_flat;

  assign cfg_in.div       = cfg_div;
  assign cfg_in.flen      = cfg_frame_len;
  assign cfg_in.last_ch   = cfg_last_ch;
  assign cfg_in.sync_slot = cfg_sync_slot;
  assign cfg_in.clk_inv   = cfg_clk_inv;
  assign act_flen         = cfg_act.flen;

  tdm_frame_ctrl #(.NUM_CH(NUM_CH)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_in   (cfg_in),
    .tick     (tick),
    .run      (run),
    .cfg_act  (cfg_act),
    .slot     (slot),
    .cap_evt  (cap_evt),
    .captured (captured)
  );

  tdm_rate_gen u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div     (cfg_act.div),
    .clk_inv (cfg_act.clk_inv),
    .tick    (tick),
    .launch  (launch),
    .oclk    (out_clk)
  );

  tdm_word_mux #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_i      (ch_i),
    .ch_q      (ch_q),
    .cap_evt   (cap_evt),
    .launch    (launch),
    .captured  (captured),
    .slot      (slot),
    .last_ch   (cfg_act.last_ch),
    .sync_slot (cfg_act.sync_slot),
    .out_data  (out_data),
    .out_sync  (out_sync),
    .snap_flat (snap_flat)
  );
endmodule

// File: rtl/tdm_iq_mux_chk.sv
module tdm_iq_mux_chk #(
  parameter int WORD_W = 32,
  parameter int SNAP_W = 256,
  parameter int FLEN_W = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              out_clk,
  input logic              out_sync,
  input logic [WORD_W-1:0] out_data,
  input logic              captured,
  input logic              cap_evt,
  input logic [SNAP_W-1:0] snap_flat,
  input logic [FLEN_W-1:0] slot,
  input logic [FLEN_W-1:0] act_flen
);
  // R6: a new word only appears together with a clock transition
  p_data_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> !$stable(out_clk));

  // R7: the marker only moves together with a clock transition
  p_sync_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_sync) |-> !$stable(out_clk));

  // R9: nothing leaves before the first capture
  p_quiet_before_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (out_data == '0 && !out_sync));

  // R8: the holding register only changes on a capture
  p_snapshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(snap_flat));

  // R4: the slot index stays inside the frame
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    captured |-> (slot < act_flen));
endmodule

bind tdm_iq_mux tdm_iq_mux_chk #(
  .WORD_W (2 * SAMP_W),
  .SNAP_W (NUM_CH * 2 * SAMP_W),
  .FLEN_W (tdm_iq_pkg::FLEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_clk   (out_clk),
  .out_sync  (out_sync),
  .out_data  (out_data),
  .captured  (captured),
  .cap_evt   (cap_evt),
  .snap_flat (snap_flat),
  .slot      (slot),
  .act_flen  (act_flen)
);

// File: tb/tdm_iq_mux_bench.sv
`timescale 1ns/1ps
module tdm_iq_mux_bench;
  localparam int NCH = 8;
  localparam int SW  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [7:0]    cfg_div, cfg_frame_len;
  logic [2:0]    cfg_last_ch, cfg_sync_slot;
  logic          cfg_clk_inv;
  logic [NCH*SW-1:0] ch_i, ch_q;
  logic          out_clk, out_sync;
  logic [31:0]   out_data;
  logic [SW-1:0] bi [NCH];
  logic [SW-1:0] bq [NCH];
  logic          tb_pol;
  int checks = 0;
  int errors = 0;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_i[c*SW +: SW] = bi[c];
      ch_q[c*SW +: SW] = bq[c];
    end
  end

  tdm_iq_mux u_tdm_iq_mux (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_frame_len(cfg_frame_len),
    .cfg_last_ch(cfg_last_ch), .cfg_sync_slot(cfg_sync_slot), .cfg_clk_inv(cfg_clk_inv),
    .ch_i(ch_i), .ch_q(ch_q), .out_clk(out_clk), .out_sync(out_sync), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int c);
    return {bi[c], bq[c]};
  endfunction

  function automatic int frame_slots(input int flen, input int n);
    return (flen > n) ? flen : n;
  endfunction

  task automatic set_pattern(input int seed);
    for (int c = 0; c < NCH; c++) begin
      bi[c] = 16'(16'h1000 * (c + 1) + seed);
      bq[c] = 16'(16'hF00F ^ (c * 16'h0123) ^ seed);
    end
  endtask

  // wait for the receiver's sampling edge and latch the bus there
  task automatic get_sample(output logic [31:0] d, output logic s, output bit moved);
    logic last_clk;
    logic [31:0] last_d;
    bit hit;
    last_clk = out_clk;
    last_d   = out_data;
    hit      = 0;
    while (!hit) begin
      @(negedge clk);
      if (out_clk != last_clk && out_clk == !tb_pol) hit = 1;
      moved    = (out_data != last_d);
      last_clk = out_clk;
      last_d   = out_data;
    end
    d = out_data;
    s = out_sync;
  endtask

  task automatic start(input int div, input int flen, input int nm1, input int sp, input bit pol);
    logic [31:0] d;
    logic s;
    bit mv;
    int f;
    rst_n = 1'b0;
    cfg_div = 8'(div); cfg_frame_len = 8'(flen);
    cfg_last_ch = 3'(nm1); cfg_sync_slot = 3'(sp); cfg_clk_inv = pol;
    tb_pol = pol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    f = frame_slots(flen, nm1 + 1);
    for (int k = 0; k < f; k++) begin
      get_sample(d, s, mv);
      chk(d == 32'h0 && !s, "R9", "first interval quiet", {d[30:0], s}, 32'h0);
    end
  endtask

  task automatic check_interval(input int n, input int f, input int sp);
    logic [31:0] d;
    logic s;
    bit mv;
    int spe;
    spe = (sp < n) ? sp : 0;
    for (int k = 0; k < f; k++) begin
      get_sample(d, s, mv);
      if (k < n) chk(d == exp_word(k), "R2", "slot word", d, exp_word(k));
      else       chk(d == exp_word(n - 1), "R4", "idle slot hold", d, exp_word(n - 1));
      chk(s == (k == spe), "R7", "marker slot", 32'(s), 32'(k == spe));
      chk(!mv, "R6", "data steady at sampling edge", 32'(mv), 32'h0);
    end
  endtask

  task automatic sync_gap(output int gap);
    logic p;
    bit seen;
    int cnt;
    p = out_sync; seen = 0; cnt = 0;
    while (1) begin
      @(negedge clk);
      if (out_sync && !p) begin
        if (seen) break;
        seen = 1; cnt = 0;
      end else cnt++;
      p = out_sync;
    end
    gap = cnt + 1;
  endtask

  task automatic clk_high(output int h);
    logic p;
    p = out_clk;
    while (!(out_clk && !p)) begin
      p = out_clk;
      @(negedge clk);
    end
    h = 0;
    while (out_clk) begin
      h++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_data == 32'h0, "R11", "reset data", out_data, 32'h0);
    chk(!out_sync, "R11", "reset marker", 32'(out_sync), 32'h0);
    chk(!out_clk, "R11", "reset clock", 32'(out_clk), 32'h0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    logic s;
    bit mv;
    set_pattern(3);
    start(1, 8, 7, 0, 1'b0);
    get_sample(d, s, mv);
    chk(d[31:16] == bi[0] && d[15:0] == bq[0], "R1", "I high Q low", d, exp_word(0));
    chk(s, "R7", "marker on slot 0", 32'(s), 32'h1);
    for (int k = 1; k < 8; k++) begin
      get_sample(d, s, mv);
      chk(d == exp_word(k), "R3", "eight channels from code 7", d, exp_word(k));
    end
    check_interval(8, 8, 0);
  endtask

  task automatic t_idle_pol();
    set_pattern(17);
    start(2, 6, 2, 2, 1'b1);
    check_interval(3, 6, 2);
    check_interval(3, 6, 2);
  endtask

  task automatic t_clamp();
    set_pattern(41);
    start(1, 4, 3, 6, 1'b0);
    check_interval(4, 4, 6);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    logic s;
    bit mv;
    logic [31:0] old_w [4];
    set_pattern(5);
    start(2, 6, 3, 1, 1'b0);
    for (int c = 0; c < 4; c++) old_w[c] = exp_word(c);
    for (int k = 0; k < 6; k++) begin
      get_sample(d, s, mv);
      chk(d == old_w[(k < 4) ? k : 3], "R8", "frame uses one capture", d, old_w[(k < 4) ? k : 3]);
      if (k == 1) set_pattern(99);
    end
    check_interval(4, 6, 1);
  endtask

  task automatic t_rate();
    int gap;
    int h;
    set_pattern(7);
    start(3, 5, 1, 0, 1'b0);
    sync_gap(gap);
    chk(gap == 30, "R4", "capture spacing 2*D*F", 32'(gap), 32'd30);
    clk_high(h);
    chk(h == 3, "R5", "clock high D cycles", 32'(h), 32'd3);
  endtask

  task automatic t_cfg_change();
    logic [31:0] d;
    logic s;
    bit mv;
    set_pattern(11);
    start(1, 4, 1, 0, 1'b0);
    get_sample(d, s, mv);
    chk(d == exp_word(0) && s, "R10", "slot 0 before change", d, exp_word(0));
    cfg_last_ch = 3'd4;
    cfg_sync_slot = 3'd3;
    for (int k = 1; k < 4; k++) begin
      get_sample(d, s, mv);
      chk(d == exp_word((k < 2) ? k : 1), "R10", "old shape kept mid-frame", d, exp_word((k < 2) ? k : 1));
      chk(!s, "R10", "old marker slot kept", 32'(s), 32'h0);
    end
    check_interval(5, 5, 3);
    check_interval(5, 5, 3);
  endtask

  task automatic t_zero_div();
    int gap;
    set_pattern(23);
    start(0, 0, 1, 1, 1'b0);
    check_interval(2, 2, 1);
    sync_gap(gap);
    chk(gap == 4, "R5", "zero divider acts as one", 32'(gap), 32'd4);
  endtask

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tb_pol = 1'b0;
    cfg_div = 8'd1; cfg_frame_len = 8'd8; cfg_last_ch = 3'd7;
    cfg_sync_slot = 3'd0; cfg_clk_inv = 1'b0;
    set_pattern(0);
    t_reset();
    t_full();
    t_idle_pol();
    t_clamp();
    t_snapshot();
    t_rate();
    t_cfg_change();
    t_zero_div();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule